// File: doc/BRIEF.md
# Add Bus Output Interface

This block drives a shared byte-wide add bus on behalf of several path channels. The channels are interleaved byte by byte. Each channel holds a slot assignment register that names the time slot it writes into, or marks it unassigned. The byte rhythm comes from one of two timing references. A mode input chooses between dedicated add-bus timing (a byte clock, a frame marker and a payload-active flag) and the drop-bus timing strobes.

On every byte, the block works out the slot number. When the payload is active and a channel owns that slot, it drives the channel's byte onto the bus, pulls the active-low add strobe low, asserts the output enable and produces an odd-parity bit. Between added bytes the bus is released. Two sticky alarms watch the bus. The first is a contention alarm, raised when two channels hold the same slot. The second is a stuck-clock alarm, raised when the add clock stops toggling while add-bus timing is in use. A single clear input drops either alarm once its cause is gone.

All logic runs on one fast system clock. The add clock is sampled as a level, and its rising edge marks a byte.

Top module: `addbus_tx`

## Requirements
- R1: With `timing_sel` high, a byte occurs in each system clock cycle where `add_clk` is sampled high after having been sampled low in the previous cycle. That byte uses `add_c1j1` and `add_spe`.
- R2: With `timing_sel` low, a byte occurs in each cycle where `drop_tick` is high. That byte uses `drop_c1j1` and `drop_spe`.
- R3: A byte whose marker input is high is slot 0. Each following byte takes the next slot in the order 0, 1, 2, 0, and so on.
- R4: On the clock edge that ends a byte cycle, `bus_add_n` goes low if the payload-active flag is high and some channel's assignment equals the slot. `bus_data` then takes that channel's byte from `ch_data` (channel k occupies bits 8k+7..8k). Otherwise `bus_add_n` goes high.
- R5: `bus_par` makes the total count of ones in `bus_data` plus `bus_par` odd.
- R6: While `bus_add_n` is high, `bus_oe` is low, `bus_data` is 0 and `bus_par` is 1. While `bus_add_n` is low, `bus_oe` is high.
- R7: All bus outputs hold their values between bytes.
- R8: A one-cycle pulse on `cfg_we` loads `cfg_slot` into the assignment of channel `cfg_ch`. The code 3 means unassigned, and an unassigned channel never adds.
- R9: When two channels hold the same assignment in the range 0..2, `alm_contention` goes high one cycle later. On the bus, the lower-numbered channel's byte wins.
- R10: `alarm_clr` clears `alm_contention` only while no clash exists. Without a clear, the alarm stays set.
- R11: With `timing_sel` high, 16 consecutive system clock cycles without a level change on `add_clk` set `alm_add_clk_stuck`. This covers both stuck high and stuck low. With `timing_sel` low, no stuck alarm is raised.
- R12: `alarm_clr` clears `alm_add_clk_stuck` unless the alarm is being set in that same cycle.
- R13: After synchronous reset, `bus_add_n`=1, `bus_oe`=0, `bus_data`=0, `bus_par`=1, both alarms are 0 and every channel is unassigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_sel | input | 1 | 1 = add-bus timing, 0 = drop-bus timing |
| add_clk | input | 1 | Add-bus byte clock, sampled as a level |
| add_c1j1 | input | 1 | Add-bus frame marker |
| add_spe | input | 1 | Add-bus payload-active flag |
| drop_tick | input | 1 | Drop-bus byte strobe |
| drop_c1j1 | input | 1 | Drop-bus frame marker |
| drop_spe | input | 1 | Drop-bus payload-active flag |
| ch_data | input | 24 | Byte offered by each channel |
| cfg_we | input | 1 | Assignment write strobe |
| cfg_ch | input | 2 | Channel to write |
| cfg_slot | input | 2 | Slot code to write (3 = unassigned) |
| alarm_clr | input | 1 | Clear for both sticky alarms |
| bus_data | output | 8 | Add-bus data byte |
| bus_add_n | output | 1 | Active-low add strobe |
| bus_par | output | 1 | Odd parity over bus_data |
| bus_oe | output | 1 | Drive enable for bus_data and bus_par |
| alm_contention | output | 1 | Sticky slot contention alarm |
| alm_add_clk_stuck | output | 1 | Sticky add clock stuck alarm |

## Verification
The contention alarm and a byte add for the contested slot can happen in the same cycle. The bench provokes this by moving a second channel onto an occupied slot while bytes keep flowing. The behavioural model then expects the alarm one cycle after the write, with the lower channel's byte on the bus. A stuck-clock alarm can also coincide with a clear pulse. The bench holds `add_clk` high and then low for more than 16 cycles and pulses `alarm_clr` at several points. Every output is compared against the model on every cycle.

// File: rtl/addbus_pkg.sv
// Shared types for the add bus output interface.
// Assumes: a byte is qualified by a single-cycle tick on the system clock.
package addbus_pkg;

    // Per-byte timing qualifiers chosen from the active reference.
    typedef struct packed {
        logic tick;   // this system clock cycle carries a byte
        logic act;    // payload is active in this byte
    } byte_tim_t;

endpackage

// File: rtl/addbus_timing.sv
// Selects the byte timing reference and tracks the slot number.
// Assumes: add_clk is slow compared with clk, so sampling it as a level
// shows every edge. Marker and active inputs are steady during the tick cycle.
module addbus_timing
    import addbus_pkg::*;
#(
    parameter int NSLOT = 3,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          timing_sel,
    input  logic          add_clk,
    input  logic          add_c1j1,
    input  logic          add_spe,
    input  logic          drop_tick,
    input  logic          drop_c1j1,
    input  logic          drop_spe,
    output byte_tim_t     tim,
    output logic [SW-1:0] cur_slot,
    output logic          add_clk_chg
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOT - 1);

    logic          add_clk_q;
    logic          add_rise;
    logic          mark;
    logic [SW-1:0] slot_q;

    // Remember the last sampled level of the add clock.
    always_ff @(posedge clk) begin
        if (!rst_n) add_clk_q <= 1'b0;
        else        add_clk_q <= add_clk;
    end

    assign add_rise    = add_clk & ~add_clk_q;
    assign add_clk_chg = add_clk ^ add_clk_q;

    // Pick tick, marker and active flag from the selected reference.
    always_comb begin
        if (timing_sel) begin
            tim.tick = add_rise;
            tim.act  = add_spe;
            mark     = add_c1j1;
        end else begin
            tim.tick = drop_tick;
            tim.act  = drop_spe;
            mark     = drop_c1j1;
        end
    end

    // Slot of the current byte: zero on the marker, otherwise next in turn.
    always_comb begin
        if (mark || slot_q == LAST_SLOT) cur_slot = '0;
        else                             cur_slot = slot_q + 1'b1;
    end

    // Hold the slot number of the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot_q <= LAST_SLOT;
        else if (tim.tick) slot_q <= cur_slot;
    end

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_SLOT);
    assert_mark_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tim.tick && mark) |=> (slot_q == '0));
    assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tim.tick |=> $stable(slot_q));
endmodule

// File: rtl/addbus_stuck_mon.sv
// Watches the add clock for a missing level change while add timing is in use.
// Assumes: add_clk_chg is one in each cycle where the sampled level differs
// from the previous cycle.
module addbus_stuck_mon #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic add_clk_chg,
    input  logic clr,
    output logic alarm
);
    localparam int CNTW = $clog2(LIMIT + 1);

    logic [CNTW-1:0] quiet_cnt;
    logic            set;

    // Count consecutive cycles without a level change, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || add_clk_chg) quiet_cnt <= '0;
        else if (quiet_cnt != CNTW'(LIMIT))   quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign set = enable && !add_clk_chg && (quiet_cnt == CNTW'(LIMIT - 1));

    // Sticky alarm; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm <= 1'b0;
        else        alarm <= set | (alarm & ~clr);
    end

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt <= CNTW'(LIMIT));
    assert_chg_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        add_clk_chg |=> (quiet_cnt == '0));
    assert_stuck_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clr) |=> alarm);
endmodule

// File: rtl/addbus_slot_map.sv
// Holds the per-channel slot assignments, selects the byte for the current
// slot and flags channels that share a slot.
// Assumes: a code of NSLOT or above means unassigned.
module addbus_slot_map #(
    parameter int NCH   = 3,
    parameter int NSLOT = 3,
    parameter int DW    = 8,
    parameter int SW    = 2,
    parameter int CW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_ch,
    input  logic [SW-1:0]     cfg_slot,
    input  logic              clr,
    input  logic [SW-1:0]     cur_slot,
    input  logic [NCH*DW-1:0] ch_data,
    output logic              hit,
    output logic [DW-1:0]     sel_data,
    output logic              alarm
);
    localparam logic [SW-1:0] NONE = SW'(NSLOT);

    logic [SW-1:0]      asg [NCH];
    logic [NCH*NCH-1:0] clash;
    logic               conflict;

    for (genvar j = 0; j < NCH; j++) begin : g_asg
        // Assignment register for one channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                          asg[j] <= NONE;
            else if (cfg_we && cfg_ch == CW'(j)) asg[j] <= cfg_slot;
        end
    end

    // Byte for the current slot; the lowest channel number takes priority.
    always_comb begin
        hit      = 1'b0;
        sel_data = '0;
        for (int j = NCH - 1; j >= 0; j--) begin
            if (asg[j] == cur_slot) begin
                hit      = 1'b1;
                sel_data = ch_data[j*DW +: DW];
            end
        end
    end

    for (genvar a = 0; a < NCH; a++) begin : g_row
        for (genvar b = 0; b < NCH; b++) begin : g_col
            if (b > a) begin : g_pair
                assign clash[a*NCH+b] = (asg[a] == asg[b]) && (asg[a] < NONE);
            end else begin : g_none
                assign clash[a*NCH+b] = 1'b0;
            end
        end
    end

    assign conflict = |clash;

    // Sticky contention alarm; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm <= 1'b0;
        else        alarm <= conflict | (alarm & ~clr);
    end

    assert_cont_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> alarm);
    assert_cont_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clr) |=> alarm);
    assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cur_slot < NONE));
endmodule

// File: rtl/addbus_tx.sv
// Add bus output interface: registers byte, strobe, parity and enable once
// per byte, and gathers the timing, slot map and clock monitor.
// Assumes: the bus outputs change only on a byte tick.
module addbus_tx
    import addbus_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int NSLOT       = 3,
    parameter int DW          = 8,
    parameter int STUCK_LIMIT = 16,
    parameter int SW          = $clog2(NSLOT + 1),
    parameter int CW          = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timing_sel,
    input  logic              add_clk,
    input  logic              add_c1j1,
    input  logic              add_spe,
    input  logic              drop_tick,
    input  logic              drop_c1j1,
    input  logic              drop_spe,
    input  logic [NCH*DW-1:0] ch_data,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_ch,
    input  logic [SW-1:0]     cfg_slot,
    input  logic              alarm_clr,
    output logic [DW-1:0]     bus_data,
    output logic              bus_add_n,
    output logic              bus_par,
    output logic              bus_oe,
    output logic              alm_contention,
    output logic              alm_add_clk_stuck
);
    byte_tim_t     tim;
    logic [SW-1:0] cur_slot;
    logic          add_clk_chg;
    logic          hit;
    logic [DW-1:0] sel_data;
    logic          add_now;
    logic [DW-1:0] next_data;

    addbus_timing #(.NSLOT(NSLOT), .SW(SW)) u_timing (
        .clk(clk), .rst_n(rst_n), .timing_sel(timing_sel),
        .add_clk(add_clk), .add_c1j1(add_c1j1), .add_spe(add_spe),
        .drop_tick(drop_tick), .drop_c1j1(drop_c1j1), .drop_spe(drop_spe),
        .tim(tim), .cur_slot(cur_slot), .add_clk_chg(add_clk_chg)
    );

    addbus_slot_map #(.NCH(NCH), .NSLOT(NSLOT), .DW(DW), .SW(SW), .CW(CW)) u_map (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_slot(cfg_slot), .clr(alarm_clr), .cur_slot(cur_slot),
        .ch_data(ch_data), .hit(hit), .sel_data(sel_data),
        .alarm(alm_contention)
    );

    addbus_stuck_mon #(.LIMIT(STUCK_LIMIT)) u_stuck (
        .clk(clk), .rst_n(rst_n), .enable(timing_sel),
        .add_clk_chg(add_clk_chg), .clr(alarm_clr),
        .alarm(alm_add_clk_stuck)
    );

    // Decide whether this byte is added and which value goes out.
    always_comb begin
        add_now   = tim.act & hit;
        next_data = add_now ? sel_data : '0;
    end

    // Bus output register, loaded once per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data  <= '0;
            bus_add_n <= 1'b1;
            bus_par   <= 1'b1;
            bus_oe    <= 1'b0;
        end else if (tim.tick) begin
            bus_data  <= next_data;
            bus_add_n <= ~add_now;
            bus_par   <= ~^next_data;
            bus_oe    <= add_now;
        end
    end

    assert_par_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ^{bus_data, bus_par});
    assert_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_add_n |-> (!bus_oe && bus_data == '0));
    assert_oe_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_add_n |-> bus_oe);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tim.tick |=> ($stable(bus_data) && $stable(bus_add_n) && $stable(bus_oe)));
endmodule

// File: tb/addbus_tx_tb_top.sv
module addbus_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timing_sel = 1'b1;
    logic        add_clk = 1'b0, add_c1j1 = 1'b0, add_spe = 1'b0;
    logic        drop_tick = 1'b0, drop_c1j1 = 1'b0, drop_spe = 1'b0;
    logic [23:0] ch_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0, cfg_slot = '0;
    logic        alarm_clr = 1'b0;
    logic [7:0]  bus_data;
    logic        bus_add_n, bus_par, bus_oe, alm_contention, alm_add_clk_stuck;

    always #2 clk = ~clk;

    addbus_tx dut_i (
        .clk(clk), .rst_n(rst_n), .timing_sel(timing_sel),
        .add_clk(add_clk), .add_c1j1(add_c1j1), .add_spe(add_spe),
        .drop_tick(drop_tick), .drop_c1j1(drop_c1j1), .drop_spe(drop_spe),
        .ch_data(ch_data), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_slot(cfg_slot),
        .alarm_clr(alarm_clr), .bus_data(bus_data), .bus_add_n(bus_add_n),
        .bus_par(bus_par), .bus_oe(bus_oe), .alm_contention(alm_contention),
        .alm_add_clk_stuck(alm_add_clk_stuck)
    );

    int    n_cmp = 0, n_bad = 0, cyc = 0, wd = 0;
    int    aclk_hold = 0;   // 0 toggle, 1 hold high, 2 hold low
    bit    done = 0;
    string phase = "R13 reset";

    // Stimulus generator: add clock, drop strobe, markers and channel bytes.
    always @(negedge clk) begin
        int ab, db;
        cyc++;
        ab = cyc / 4;
        db = cyc / 3;
        if (aclk_hold == 1)      add_clk <= 1'b1;
        else if (aclk_hold == 2) add_clk <= 1'b0;
        else                     add_clk <= ((cyc / 2) % 2) == 1;
        add_c1j1  <= (ab % 7) == 0;
        add_spe   <= (ab % 5) != 3;
        drop_tick <= (cyc % 3) == 0;
        drop_c1j1 <= (db % 8) == 0;
        drop_spe  <= (db % 6) != 5;
        for (int k = 0; k < 3; k++) ch_data[k*8 +: 8] <= 8'((cyc * 37 + k * 91 + 5) & 255);
    end

    // Behavioural reference model, stepped on every rising edge.
    int m_asg[3];
    int m_slot, m_cnt, m_data, m_par;
    bit m_prev, m_add_n, m_oe, m_cont, m_stuck;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) m_asg[k] = 3;
            m_slot = 2; m_cnt = 0; m_prev = 0;
            m_data = 0; m_par = 1; m_add_n = 1; m_oe = 0; m_cont = 0; m_stuck = 0;
        end else begin
            bit tick, mk, act, chg, clash, sset;
            int win;
            chg  = add_clk != m_prev;
            tick = timing_sel ? (add_clk && !m_prev) : drop_tick;
            mk   = timing_sel ? add_c1j1 : drop_c1j1;
            act  = timing_sel ? add_spe : drop_spe;
            if (tick) begin
                m_slot = mk ? 0 : (m_slot + 1) % 3;
                win = -1;
                for (int k = 2; k >= 0; k--) if (m_asg[k] == m_slot) win = k;
                if (act && win >= 0) begin
                    m_add_n = 0; m_oe = 1; m_data = int'(ch_data[win*8 +: 8]);
                end else begin
                    m_add_n = 1; m_oe = 0; m_data = 0;
                end
                m_par = ($countones(m_data) % 2 == 0) ? 1 : 0;
            end
            clash = 0;
            for (int a = 0; a < 3; a++)
                for (int b = a + 1; b < 3; b++)
                    if (m_asg[a] == m_asg[b] && m_asg[a] < 3) clash = 1;
            m_cont = clash || (m_cont && !alarm_clr);
            sset = 0;
            if (!timing_sel || chg) m_cnt = 0;
            else begin
                if (m_cnt == 15) sset = 1;
                if (m_cnt < 16) m_cnt++;
            end
            m_stuck = sset || (m_stuck && !alarm_clr);
            if (cfg_we && cfg_ch < 3) m_asg[cfg_ch] = int'(cfg_slot);
            m_prev = add_clk;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 add_n", int'(bus_add_n), int'(m_add_n));
            chk("R4 data", int'(bus_data), m_data);
            chk("R5 parity", int'(bus_par), m_par);
            chk("R6 oe", int'(bus_oe), int'(m_oe));
            chk("R9 contention", int'(alm_contention), int'(m_cont));
            chk("R11 stuck", int'(alm_add_clk_stuck), int'(m_stuck));
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int ch, int sl);
        @(negedge clk);
        cfg_we <= 1'b1; cfg_ch <= 2'(ch); cfg_slot <= 2'(sl);
        @(negedge clk);
        cfg_we <= 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        alarm_clr <= 1'b1;
        @(negedge clk);
        alarm_clr <= 1'b0;
    endtask

    task automatic report();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, wd, 100000);
            report();
        end
    end

    initial begin
        run(5);
        rst_n <= 1'b1;
        @(negedge clk);
        // R13: reset values at the ports, all channels unassigned
        chk("R13 add_n", int'(bus_add_n), 1);
        chk("R13 oe", int'(bus_oe), 0);
        chk("R13 data", int'(bus_data), 0);
        chk("R13 par", int'(bus_par), 1);
        chk("R13 alarms", int'({alm_contention, alm_add_clk_stuck}), 0);
        phase = "R8 unassigned no add";
        run(60);
        phase = "R1 R3 R4 R8 add timing two channels";
        cfg(0, 0); cfg(1, 2); cfg(2, 3);
        run(200);
        phase = "R1 R3 R7 three channels";
        cfg(2, 1);
        run(200);
        phase = "R2 R3 drop timing, add clock held";
        timing_sel <= 1'b0; aclk_hold = 1;
        run(150);
        chk("R11 no stuck in drop mode", int'(alm_add_clk_stuck), 0);
        phase = "R11 stuck high";
        timing_sel <= 1'b1;
        run(40);
        chk("R11 stuck high flagged", int'(alm_add_clk_stuck), 1);
        phase = "R12 clear while still stuck";
        pulse_clr();
        run(5);
        chk("R12 cleared", int'(alm_add_clk_stuck), 0);
        phase = "R11 stuck low";
        aclk_hold = 2;
        run(40);
        chk("R11 stuck low flagged", int'(alm_add_clk_stuck), 1);
        aclk_hold = 0;
        run(20);
        pulse_clr();
        run(3);
        chk("R12 cleared after recovery", int'(alm_add_clk_stuck), 0);
        phase = "R9 clash ch1 onto slot 0";
        cfg(1, 0);
        run(60);
        chk("R9 contention raised", int'(alm_contention), 1);
        phase = "R10 clear during clash";
        pulse_clr();
        run(4);
        chk("R10 alarm kept", int'(alm_contention), 1);
        phase = "R10 clash removed";
        cfg(1, 2);
        run(10);
        chk("R10 alarm sticky", int'(alm_contention), 1);
        pulse_clr();
        run(4);
        chk("R10 alarm cleared", int'(alm_contention), 0);
        phase = "R2 R4 drop timing final";
        timing_sel <= 1'b0;
        run(120);
        report();
    end
endmodule